// File: doc/BRIEF.md
# Folded Two-Dimensional Integer Cosine Transform

This block computes a separable two-dimensional integer cosine transform of a square block of signed samples, `Z = C · X · Cᵀ`, with one shared one-dimensional transform lane. The lane first works through the rows of the input matrix (row pass). It writes each finished row into a transpose store made of per-row registers with individual load enables. It then works through the columns of that store (column pass) and streams out one final coefficient per cycle. No rounding or scaling is applied between the passes, so the results are exact integers.

A size code taken at `start` chooses the transform size. Only the top-left P×P corner of the input port is used. Each pass takes P² cycles, so a complete transform takes 2P² cycles. The caller keeps `in_mat` stable through the row pass. It may change the port freely once the column pass has begun.

Top module: `xf2d_fold`

## Requirements
- R1: Each result equals `Σi Σj C[u][i]·X[i][j]·C[v][j]` in full precision. Sample X[r][j] sits at bits `[(r·MAXN+j)·IN_W +: IN_W]` of `in_mat`, in two's complement. For a P-point size, C[0][n]=64. For u>0, C[u][n]=±T(m) with m=(u·(32/P)·(2n+1)) mod 128. The sign is + for m<32 or m>96 and − otherwise, and T is the magnitude for the folded angle. T(1..31) = 90,90,90,89,88,87,85,83,82,80,78,75,73,70,67,64,61,57,54,50,46,43,38,36,31,25,22,18,13,9,4.
- R2: Size code c in 0..MAX_LOG−1 selects P = 2^(MAX_LOG−c). Codes ≥ MAX_LOG select P = 2. Samples outside the top-left P×P corner have no effect.
- R3: Exactly P² results are streamed with `res_valid`. The column index `res_v` is the outer loop and the row index `res_u` is the inner loop, both starting at 0.
- R4: A row of the transpose store is loaded only when all P results of that input row are complete, and at most one row enable is active in any cycle.
- R5: The column pass starts in the cycle right after the last row is stored. The first valid result appears P²+1 clock edges after the edge that accepts `start`.
- R6: `done` is a one-cycle pulse in the cycle after the last valid result, and `busy` is already low when it appears.
- R7: `start` while `busy` is high is ignored. The size and result sequence of the running transform are unchanged.
- R8: `in_mat` is read only during the row pass. Changing it during the column pass does not alter the results.
- R9: After synchronous reset, `busy`, `res_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform when idle |
| size_code | input | 3 | Transform size select |
| in_mat | input | MAXN·MAXN·IN_W | Input sample matrix, row-major |
| busy | output | 1 | A transform is in progress |
| res_valid | output | 1 | Result word valid |
| res_data | output | ACC_W | Signed transform coefficient |
| res_u | output | MAX_LOG | Vertical frequency index of the result |
| res_v | output | MAX_LOG | Horizontal frequency index of the result |
| done | output | 1 | Transform finished pulse |

## Verification
Each size is tried with its own pattern:
- A single impulse checks the first row and column of the coefficient matrix in isolation.
- A constant block must put all of its energy into the DC term.
- A checkerboard excites only the highest frequencies, and would show up a sign error in the folded-angle coefficients.
- Ramps and pseudo-random data mix every coefficient.
- Alternating extreme values drive the accumulators to their widest range, so any width shortfall appears.

Further runs check three things: that a start arriving mid-run is ignored, that an input change during the column pass has no effect, and that an out-of-range size code falls back to two points while the unused samples around it are non-zero.

// File: rtl/xf_pkg.sv
package xf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2
    } phase_e;

    // magnitude of the scaled cosine for folded angle index m (1..31)
    function automatic logic signed [7:0] cos_mag(input int m);
        logic signed [7:0] v;
        case (m)
            1, 2, 3: v = 8'sd90;
            4:  v = 8'sd89;  5:  v = 8'sd88;  6:  v = 8'sd87;  7:  v = 8'sd85;
            8:  v = 8'sd83;  9:  v = 8'sd82;  10: v = 8'sd80;  11: v = 8'sd78;
            12: v = 8'sd75;  13: v = 8'sd73;  14: v = 8'sd70;  15: v = 8'sd67;
            16: v = 8'sd64;  17: v = 8'sd61;  18: v = 8'sd57;  19: v = 8'sd54;
            20: v = 8'sd50;  21: v = 8'sd46;  22: v = 8'sd43;  23: v = 8'sd38;
            24: v = 8'sd36;  25: v = 8'sd31;  26: v = 8'sd25;  27: v = 8'sd22;
            28: v = 8'sd18;  29: v = 8'sd13;  30: v = 8'sd9;   31: v = 8'sd4;
            default: v = 8'sd0;
        endcase
        return v;
    endfunction

    // coefficient of row k32 (expressed on the 32-point grid), column n
    function automatic logic signed [7:0] coef_at(input int k32, input int n);
        int m;
        if (k32 == 0) return 8'sd64;
        m = (k32 * (2 * n + 1)) % 128;
        if (m < 32)      return cos_mag(m);
        else if (m < 64) return -cos_mag(64 - m);
        else if (m < 96) return -cos_mag(m - 64);
        else             return cos_mag(128 - m);
    endfunction

endpackage

// File: rtl/xf_seq.sv
module xf_seq #(
    parameter int MAX_LOG = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          size_code,
    output xf_pkg::phase_e      phase,
    output logic [MAX_LOG-1:0]  idx,
    output logic [MAX_LOG-1:0]  kk,
    output logic [2:0]          lg,
    output logic                end_k,
    output logic                end_idx
);
    import xf_pkg::*;

    logic [MAX_LOG-1:0] last;

    always_comb begin
        last    = MAX_LOG'((32'd1 << lg) - 32'd1);
        end_k   = (kk == last);
        end_idx = (idx == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            kk    <= '0;
            lg    <= 3'd1;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= PH_ROW;
                idx   <= '0;
                kk    <= '0;
                lg    <= (size_code >= 3'(MAX_LOG)) ? 3'd1 : 3'(MAX_LOG) - size_code;
            end
        end else if (end_k) begin
            kk <= '0;
            if (end_idx) begin
                idx   <= '0;
                phase <= (phase == PH_ROW) ? PH_COL : PH_IDLE;
            end else begin
                idx <= idx + 1'b1;
            end
        end else begin
            kk <= kk + 1'b1;
        end
    end
endmodule

// File: rtl/xf_dot.sv
module xf_dot #(
    parameter int MAXN    = 32,
    parameter int DW      = 22,
    parameter int ACC_W   = 35,
    parameter int MAX_LOG = 5
) (
    input  logic signed [DW-1:0]    vec [MAXN],
    input  logic [MAX_LOG-1:0]      kk,
    input  logic [2:0]              lg,
    output logic signed [ACC_W-1:0] sum
);
    int k32;
    int plen;
    logic signed [ACC_W-1:0] prods [MAXN];

    always_comb begin
        k32  = int'(kk) << (5 - int'(lg));
        plen = 1 << lg;
    end

    for (genvar n = 0; n < MAXN; n++) begin : g_lane
        logic signed [7:0] cf;
        always_comb begin
            cf = xf_pkg::coef_at(k32, n);
            prods[n] = (n < plen) ? ACC_W'(cf) * ACC_W'(vec[n]) : '0;
        end
    end

    always_comb begin
        sum = '0;
        for (int n = 0; n < MAXN; n++) sum = sum + prods[n];
    end
endmodule

// File: rtl/xf_tbuf.sv
module xf_tbuf #(
    parameter int MAXN = 32,
    parameter int EW   = 22,
    parameter int IW   = 5
) (
    input  logic                 clk,
    input  logic [MAXN-1:0]      row_en,
    input  logic signed [EW-1:0] row_in  [MAXN],
    input  logic [IW-1:0]        col_sel,
    output logic signed [EW-1:0] col_out [MAXN]
);
    for (genvar r = 0; r < MAXN; r++) begin : g_row
        logic signed [EW-1:0] row_q [MAXN];
        always_ff @(posedge clk) begin
            if (row_en[r]) begin
                for (int c = 0; c < MAXN; c++) row_q[c] <= row_in[c];
            end
        end
        assign col_out[r] = row_q[col_sel];
    end
endmodule

// File: rtl/xf2d_fold.sv
module xf2d_fold #(
    parameter int MAX_LOG = 5,
    parameter int IN_W    = 9,
    localparam int MAXN   = 1 << MAX_LOG,
    localparam int ROW_W  = IN_W + 8 + MAX_LOG,
    localparam int ACC_W  = ROW_W + 8 + MAX_LOG
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [2:0]                  size_code,
    input  logic [MAXN*MAXN*IN_W-1:0]   in_mat,
    output logic                        busy,
    output logic                        res_valid,
    output logic signed [ACC_W-1:0]     res_data,
    output logic [MAX_LOG-1:0]          res_u,
    output logic [MAX_LOG-1:0]          res_v,
    output logic                        done
);
    import xf_pkg::*;

    phase_e               phase;
    logic [MAX_LOG-1:0]   idx, kk;
    logic [2:0]           lg;
    logic                 end_k, end_idx;
    logic signed [ROW_W-1:0] dot_in  [MAXN];
    logic signed [ROW_W-1:0] col_out [MAXN];
    logic signed [ROW_W-1:0] stage   [MAXN];
    logic signed [ROW_W-1:0] row_in  [MAXN];
    logic signed [ACC_W-1:0] dot_sum;
    logic signed [ROW_W-1:0] row_res;
    logic [MAXN-1:0]      row_en;
    logic                 last_q;

    xf_seq #(.MAX_LOG(MAX_LOG)) u_seq (
        .clk(clk), .rst(rst), .start(start), .size_code(size_code),
        .phase(phase), .idx(idx), .kk(kk), .lg(lg),
        .end_k(end_k), .end_idx(end_idx)
    );

    // source select: input rows in the row pass, stored columns afterwards
    always_comb begin
        for (int n = 0; n < MAXN; n++) begin
            if (phase == PH_COL)
                dot_in[n] = col_out[n];
            else
                dot_in[n] = ROW_W'($signed(in_mat[(int'(idx) * MAXN + n) * IN_W +: IN_W]));
        end
    end

    xf_dot #(.MAXN(MAXN), .DW(ROW_W), .ACC_W(ACC_W), .MAX_LOG(MAX_LOG)) u_dot (
        .vec(dot_in), .kk(kk), .lg(lg), .sum(dot_sum)
    );

    always_comb begin
        row_res = dot_sum[ROW_W-1:0];
        for (int n = 0; n < MAXN; n++)
            row_in[n] = (n == int'(kk)) ? row_res : stage[n];
        row_en = (phase == PH_ROW && end_k) ? (MAXN'(1) << idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (phase == PH_ROW) stage[kk] <= row_res;
    end

    xf_tbuf #(.MAXN(MAXN), .EW(ROW_W), .IW(MAX_LOG)) u_buf (
        .clk(clk), .row_en(row_en), .row_in(row_in),
        .col_sel(idx), .col_out(col_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            last_q    <= 1'b0;
            done      <= 1'b0;
        end else begin
            res_valid <= (phase == PH_COL);
            last_q    <= (phase == PH_COL) && end_k && end_idx;
            done      <= last_q;
        end
        res_data <= dot_sum;
        res_u    <= kk;
        res_v    <= idx;
    end

    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/xf2d_fold_chk.sv
module xf2d_fold_chk #(
    parameter int MAXN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            res_valid,
    input logic            done,
    input logic [MAXN-1:0] row_en,
    input xf_pkg::phase_e  phase,
    input logic [2:0]      lg
);
    import xf_pkg::*;

    a_r4_single_row_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en));

    a_r5_col_after_last_row: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_COL) |-> $past(|row_en));

    a_r6_done_follows_last: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(res_valid) && !res_valid && !busy));

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_busy_keeps_size: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(lg));

    a_r7_idle_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind xf2d_fold xf2d_fold_chk #(.MAXN(MAXN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .res_valid(res_valid), .done(done), .row_en(row_en),
    .phase(phase), .lg(lg)
);

// File: tb/sim_xf2d_fold.sv
module sim_xf2d_fold;
    localparam int ML = 5;
    localparam int N  = 32;
    localparam int W  = 9;
    localparam int AW = W + 8 + ML + 8 + ML;

    // {flags[1:0] (bit0 mid-run start, bit1 change input), code[2:0], pattern[2:0], seed[7:0]}
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 3'd0, 3'd4, 8'd1},
        {2'd0, 3'd1, 3'd0, 8'd200},
        {2'd0, 3'd2, 3'd2, 8'd77},
        {2'd0, 3'd3, 3'd3, 8'd0},
        {2'd0, 3'd4, 3'd5, 8'd0},
        {2'd0, 3'd7, 3'd1, 8'd100},
        {2'd0, 3'd0, 3'd5, 8'd0},
        {2'd1, 3'd2, 3'd4, 8'd9},
        {2'd2, 3'd1, 3'd3, 8'd0}
    };

    localparam int CT [32] = '{0, 90, 90, 90, 89, 88, 87, 85, 83, 82, 80, 78, 75, 73, 70, 67,
                               64, 61, 57, 54, 50, 46, 43, 38, 36, 31, 25, 22, 18, 13, 9, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] size_code = 3'd0;
    logic [N*N*W-1:0] in_mat = '0;
    logic busy, res_valid, done;
    logic signed [AW-1:0] res_data;
    logic [ML-1:0] res_u, res_v;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int xm [N][N];
    longint tr [N][N];
    longint zr [N][N];

    always #5 clk = ~clk;

    xf2d_fold u0 (
        .clk(clk), .rst(rst), .start(start), .size_code(size_code), .in_mat(in_mat),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_u(res_u), .res_v(res_v), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bc(input int u, input int n, input int p);
        int m;
        if (u == 0) return 64;
        m = (u * (32 / p) * (2 * n + 1)) % 128;
        if (m < 32) return CT[m];
        if (m < 64) return -CT[64 - m];
        if (m < 96) return -CT[m - 64];
        return CT[128 - m];
    endfunction

    task automatic fill(input int pat, input int seed);
        int unsigned st;
        st = 32'(seed) + 32'd7;
        for (int r = 0; r < N; r++) begin
            for (int j = 0; j < N; j++) begin
                int v;
                case (pat)
                    0: v = (r == 0 && j == 0) ? seed : 0;
                    1: v = seed;
                    2: v = ((r + j) % 2 == 1) ? seed : -seed;
                    3: v = ((r * 7 + j * 3) % 512) - 256;
                    4: begin
                        st = st * 32'd1103515245 + 32'd12345;
                        v = int'((st >> 16) & 32'd511) - 256;
                    end
                    default: v = ((r * j) % 2 == 1) ? 255 : -256;
                endcase
                xm[r][j] = v;
                in_mat[(r * N + j) * W +: W] = v[W-1:0];
            end
        end
    endtask

    task automatic compute_ref(input int p);
        for (int r = 0; r < p; r++)
            for (int k = 0; k < p; k++) begin
                longint s = 0;
                for (int j = 0; j < p; j++) s += longint'(bc(k, j, p)) * xm[r][j];
                tr[r][k] = s;
            end
        for (int u = 0; u < p; u++)
            for (int v = 0; v < p; v++) begin
                longint s = 0;
                for (int r = 0; r < p; r++) s += longint'(bc(u, r, p)) * tr[r][v];
                zr[u][v] = s;
            end
    endtask

    task automatic run_case(input logic [15:0] e);
        int code, pat, seed, flags, p, t, cnt, tdone;
        string tag;
        flags = int'(e[15:14]);
        code  = int'(e[13:11]);
        pat   = int'(e[10:8]);
        seed  = int'(e[7:0]);
        p = (code >= ML) ? 2 : (N >> code);
        if (flags[1]) tag = "R8";
        else if (flags[0]) tag = "R7";
        else if (code >= ML) tag = "R2";
        else tag = "R1";
        fill(pat, seed);
        compute_ref(p);
        @(negedge clk);
        size_code = 3'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 1;
        cnt = 0;
        tdone = -1;
        while (t <= 2 * p * p + 4) begin
            if (res_valid) begin
                if (cnt == 0) chk(t == p * p + 2, "R5 first result timing", t, p * p + 2);
                if (cnt < p * p) begin
                    // R3 ordering; R4 row loads shape every stored value checked here
                    chk(int'(res_u) == cnt % p, "R3 res_u order", res_u, cnt % p);
                    chk(int'(res_v) == cnt / p, "R3 res_v order", res_v, cnt / p);
                    chk(longint'(res_data) == zr[cnt % p][cnt / p], tag,
                        longint'(res_data), zr[cnt % p][cnt / p]);
                end
                cnt++;
            end
            if (done) begin
                tdone = t;
                chk(!busy, "R6 busy low at done", busy, 0);
            end
            if (flags[0] && t == 5) begin
                size_code = 3'd4;
                start = 1'b1;
            end
            if (flags[0] && t == 6) start = 1'b0;
            if (flags[1] && t == p * p + 3) in_mat = ~in_mat;
            @(negedge clk);
            t++;
        end
        chk(cnt == p * p, flags[0] ? "R7 result count" : "R3 result count", cnt, p * p);
        chk(tdone == 2 * p * p + 2, "R6 done timing", tdone, 2 * p * p + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R9 busy after reset", busy, 0);
        chk(!res_valid, "R9 res_valid after reset", res_valid, 0);
        chk(!done, "R9 done after reset", done, 0);
        for (int i = 0; i < NV; i++) run_case(VEC[i]);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule